// File: doc/BRIEF.md
# Priority Interrupt Controller with Vectoring

This controller gathers up to thirteen level-sensitive interrupt lines. It picks the one that should reach the processor and presents that choice as a 3-bit interrupt level and an 8-bit vector number. Each line has an 8-bit control register. The low five bits of that register form a combined level/priority value, bits 4:2 of which are the interrupt level. Bit 7 chooses between a computed autovector and a vector taken from a programmable register. A 16-bit mask register can shut individual lines out of the arbitration.

Software programs the controller through a simple word-wide register port. Writes are synchronous and reads are combinational. Pending state is sampled from the lines every clock. The level and vector outputs are registered, so the processor sees a stable request from one clock to the next.

Top module: `prio_intc`

## Requirements
- R1: After reset the control registers of lines 1..7 hold 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C; line 8 holds 0x1C; lines 9..11 hold 0x80; lines 12 and 13 hold 0x00; the mask holds 0x3FFE; the watchdog vector register and both serial vector registers hold 0x0F; level and vector read 0.
- R2: Pending bit i (i = 1..13) equals irq_lines[i] as sampled at the previous clock edge; irq_lines[0] is never pending and has no effect on the outputs.
- R3: The pending register (address 17) is read-only; a write to it changes neither its contents nor the outputs.
- R4: A line whose mask bit (bit i of the mask register, 1 = masked) is set never takes part in arbitration.
- R5: Among unmasked pending lines the one with the largest control bits 4:0 wins; on equal values the lower-numbered line wins.
- R6: If the winning value is below 4 (level bits zero), or nothing is pending and unmasked, irq_level is 0 and irq_vector is 0.
- R7: irq_level equals bits 4:2 of the winner's control register.
- R8: When bit 7 of the winner's control register is 1, irq_vector is 24 plus the level.
- R9: When bit 7 is 0, irq_vector is the watchdog vector register for line 8, serial vector register 0 for line 12, serial vector register 1 for line 13, and 0x0F for any other line.
- R10: irq_level and irq_vector change exactly one clock edge after the pending, mask, control or vector registers change (two edges after a line changes).
- R11: Register map: addresses 1..13 are the control registers (data bits 7:0), 16 the mask (bits 15:0), 17 pending, 18 the watchdog vector, 19 and 20 the serial vectors (bits 7:0); a write takes effect at the next edge; address 0 and unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 14 | Level-sensitive request lines, bit i = line i, bit 0 unused |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| irq_level | output | 3 | Interrupt level presented to the processor |
| irq_vector | output | 8 | Vector number presented to the processor |

## Verification
Two things can land on the same clock edge: a line changing and a register write that re-ranks the lines, such as a new control value or a new mask. The random phase often changes irq_lines on the same cycle that it writes a control, mask or vector register. After the outputs settle, it compares them with a bench model that uses both updated values. A directed case times the one-edge output latency against a line change. Separate directed cases cover ties, the level cutoff and every vector source.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NUM_SRC  = 14;
    localparam int CTRL_W   = 8;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 5;
    localparam int PRIO_W   = 5;
    localparam int LEVEL_W  = 3;
    localparam int VEC_W    = 8;
    localparam int IDX_W    = $clog2(NUM_SRC);

    localparam logic [ADDR_W-1:0] A_MASK = 5'd16;
    localparam logic [ADDR_W-1:0] A_PEND = 5'd17;
    localparam logic [ADDR_W-1:0] A_WDV  = 5'd18;
    localparam logic [ADDR_W-1:0] A_SV0  = 5'd19;
    localparam logic [ADDR_W-1:0] A_SV1  = 5'd20;

    localparam int SRC_WDOG = 8;
    localparam int SRC_SER0 = 12;
    localparam int SRC_SER1 = 13;

    localparam logic [PRIO_W-1:0] MIN_PRIO     = 5'd4;
    localparam logic [VEC_W-1:0]  AUTOVEC_BASE = 8'd24;
    localparam logic [VEC_W-1:0]  FALLBACK_VEC = 8'h0F;
    localparam logic [VEC_W-1:0]  VEC_RESET    = 8'h0F;
    localparam logic [DATA_W-1:0] MASK_RESET   = 16'h3FFE;

    typedef struct packed {
        logic [LEVEL_W-1:0] level;
        logic [VEC_W-1:0]   vector;
    } irq_out_t;

    function automatic logic [CTRL_W-1:0] ctrl_reset_val(input int src);
        if (src >= 1 && src <= 7)
            return CTRL_W'(src * 4);
        else if (src == 8)
            return 8'h1C;
        else if (src >= 9 && src <= 11)
            return 8'h80;
        else
            return 8'h00;
    endfunction

endpackage

// File: rtl/intc_regfile.sv
module intc_regfile
    import intc_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSRC-1:0]              lines,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [NSRC-1:0][CTRL_W-1:0]  ctrl,
    output logic [DATA_W-1:0]            mask,
    output logic [NSRC-1:0]              pend,
    output logic [VEC_W-1:0]             wdog_vec,
    output logic [VEC_W-1:0]             ser_vec0,
    output logic [VEC_W-1:0]             ser_vec1
);

    typedef struct packed {
        logic [NSRC-1:0][CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0]           mask;
        logic [NSRC-1:0]             pend;
        logic [VEC_W-1:0]            wdv;
        logic [VEC_W-1:0]            sv0;
        logic [VEC_W-1:0]            sv1;
    } regs_t;

    regs_t regs_d, regs_q;

    function automatic regs_t reset_regs();
        regs_t r;
        for (int i = 0; i < NSRC; i++)
            r.ctrl[i] = ctrl_reset_val(i);
        r.mask = MASK_RESET;
        r.pend = '0;
        r.wdv  = VEC_RESET;
        r.sv0  = VEC_RESET;
        r.sv1  = VEC_RESET;
        return r;
    endfunction

    always_comb begin
        regs_d = regs_q;
        regs_d.pend = lines;
        regs_d.pend[0] = 1'b0;
        if (we) begin
            for (int i = 1; i < NSRC; i++)
                if (addr == ADDR_W'(i))
                    regs_d.ctrl[i] = wdata[CTRL_W-1:0];
            case (addr)
                A_MASK:  regs_d.mask = wdata;
                A_WDV:   regs_d.wdv  = wdata[VEC_W-1:0];
                A_SV0:   regs_d.sv0  = wdata[VEC_W-1:0];
                A_SV1:   regs_d.sv1  = wdata[VEC_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            regs_q <= reset_regs();
        else
            regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        for (int i = 1; i < NSRC; i++)
            if (addr == ADDR_W'(i))
                rdata = DATA_W'(regs_q.ctrl[i]);
        case (addr)
            A_MASK:  rdata = regs_q.mask;
            A_PEND:  rdata = DATA_W'(regs_q.pend);
            A_WDV:   rdata = DATA_W'(regs_q.wdv);
            A_SV0:   rdata = DATA_W'(regs_q.sv0);
            A_SV1:   rdata = DATA_W'(regs_q.sv1);
            default: ;
        endcase
    end

    assign ctrl     = regs_q.ctrl;
    assign mask     = regs_q.mask;
    assign pend     = regs_q.pend;
    assign wdog_vec = regs_q.wdv;
    assign ser_vec0 = regs_q.sv0;
    assign ser_vec1 = regs_q.sv1;

    // R3: a write aimed at the pending register leaves it tracking the lines only
    a_r3_pend_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_PEND) |=> (pend == ($past(lines) & ~NSRC'(1))));

    // R11: a mask write lands at the next edge
    a_r11_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_MASK) |=> (mask == $past(wdata)));

    // R2: line 0 never reaches the pending register
    a_r2_line0_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lines[0]) |-> !pend[0]);

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]             pend,
    input  logic [DATA_W-1:0]           mask,
    input  logic [NSRC-1:0][CTRL_W-1:0] ctrl,
    output logic                        win_valid,
    output logic [IW-1:0]               win_idx,
    output logic [PRIO_W-1:0]           win_prio
);

    logic [PRIO_W-1:0] best;
    logic [IW-1:0]     best_idx;

    always_comb begin
        best     = '0;
        best_idx = '0;
        // strict comparison keeps the lower-numbered line on a tie
        for (int i = 1; i < NSRC; i++) begin
            if (pend[i] && !mask[i] && (ctrl[i][PRIO_W-1:0] > best)) begin
                best     = ctrl[i][PRIO_W-1:0];
                best_idx = IW'(i);
            end
        end
    end

    assign win_valid = (best >= MIN_PRIO);
    assign win_idx   = best_idx;
    assign win_prio  = best;

endmodule

// File: rtl/intc_vecgen.sv
module intc_vecgen
    import intc_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic              win_valid,
    input  logic [IW-1:0]     win_idx,
    input  logic [CTRL_W-1:0] win_ctrl,
    input  logic [VEC_W-1:0]  wdog_vec,
    input  logic [VEC_W-1:0]  ser_vec0,
    input  logic [VEC_W-1:0]  ser_vec1,
    output irq_out_t          req
);

    localparam logic [IW-1:0] IDX_WDOG = IW'(SRC_WDOG);
    localparam logic [IW-1:0] IDX_SER0 = IW'(SRC_SER0);
    localparam logic [IW-1:0] IDX_SER1 = IW'(SRC_SER1);

    logic [LEVEL_W-1:0] lvl;

    always_comb begin
        lvl = win_ctrl[PRIO_W-1:2];
        req = '0;
        if (win_valid) begin
            req.level = lvl;
            if (win_ctrl[CTRL_W-1])
                req.vector = AUTOVEC_BASE + VEC_W'(lvl);
            else begin
                case (win_idx)
                    IDX_WDOG: req.vector = wdog_vec;
                    IDX_SER0: req.vector = ser_vec0;
                    IDX_SER1: req.vector = ser_vec1;
                    default:  req.vector = FALLBACK_VEC;
                endcase
            end
        end
    end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   irq_lines,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic [LEVEL_W-1:0]   irq_level,
    output logic [VEC_W-1:0]     irq_vector
);

    logic [NUM_SRC-1:0][CTRL_W-1:0] ctrl;
    logic [DATA_W-1:0]              mask;
    logic [NUM_SRC-1:0]             pend;
    logic [VEC_W-1:0]               wdog_vec, ser_vec0, ser_vec1;
    logic                           win_valid;
    logic [IDX_W-1:0]               win_idx;
    logic [PRIO_W-1:0]              win_prio;
    logic [CTRL_W-1:0]              win_ctrl;
    irq_out_t                       out_d, out_q;

    intc_regfile #(.NSRC(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines    (irq_lines),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .ctrl     (ctrl),
        .mask     (mask),
        .pend     (pend),
        .wdog_vec (wdog_vec),
        .ser_vec0 (ser_vec0),
        .ser_vec1 (ser_vec1)
    );

    intc_arbiter #(.NSRC(NUM_SRC)) u_arb (
        .pend      (pend),
        .mask      (mask),
        .ctrl      (ctrl),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    always_comb begin
        win_ctrl = '0;
        for (int i = 1; i < NUM_SRC; i++)
            if (win_idx == IDX_W'(i))
                win_ctrl = ctrl[i];
    end

    intc_vecgen #(.NSRC(NUM_SRC)) u_vec (
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_ctrl  (win_ctrl),
        .wdog_vec  (wdog_vec),
        .ser_vec0  (ser_vec0),
        .ser_vec1  (ser_vec1),
        .req       (out_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign irq_level  = out_q.level;
    assign irq_vector = out_q.vector;

    // R6: no level means no vector
    a_r6_quiet_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == '0) |-> (irq_vector == '0));

    // R4: the chosen line is pending and unmasked
    a_r4_winner_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (pend[win_idx] && !mask[win_idx]));

    // R5: the winner's value is not below the cutoff
    a_r5_winner_prio: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_prio >= MIN_PRIO));

    // R7: a valid winner yields a nonzero level one edge later
    a_r7_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> (irq_level != '0));

    // R8: autovector winner gives base plus level
    a_r8_autovector: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && win_ctrl[CTRL_W-1]) |=> (irq_vector == AUTOVEC_BASE + VEC_W'(irq_level)));

    // R10: unchanged register state keeps the outputs unchanged
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(pend) && $stable(mask) && $stable(ctrl) &&
         $stable({wdog_vec, ser_vec0, ser_vec1})) |=> $stable(out_q));

endmodule

// File: tb/tb_prio_intc.sv
module tb_prio_intc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] irq_lines = '0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0]  sh_ctrl [14];
    logic [15:0] sh_mask;
    logic [7:0]  sh_wdv, sh_sv0, sh_sv1;

    always #5 clk = ~clk;

    prio_intc dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_lines  (irq_lines),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_level  (irq_level),
        .irq_vector (irq_vector)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] model();
        logic [4:0] best = '0;
        int idx = 0;
        logic [2:0] lvl;
        logic [7:0] vec;
        for (int i = 1; i < 14; i++)
            if (irq_lines[i] && !sh_mask[i] && sh_ctrl[i][4:0] > best) begin
                best = sh_ctrl[i][4:0];
                idx = i;
            end
        if (best < 5'd4) return '0;
        lvl = sh_ctrl[idx][4:2];
        if (sh_ctrl[idx][7]) vec = 8'd24 + {5'd0, lvl};
        else if (idx == 8)  vec = sh_wdv;
        else if (idx == 12) vec = sh_sv0;
        else if (idx == 13) vec = sh_sv1;
        else                vec = 8'h0F;
        return {lvl, vec};
    endfunction

    function automatic logic [15:0] shadow_read(input logic [4:0] a);
        if (a >= 5'd1 && a <= 5'd13) return {8'h00, sh_ctrl[a]};
        case (a)
            5'd16:   return sh_mask;
            5'd17:   return {2'b00, irq_lines & 14'h3FFE};
            5'd18:   return {8'h00, sh_wdv};
            5'd19:   return {8'h00, sh_sv0};
            5'd20:   return {8'h00, sh_sv1};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic shadow_write(input logic [4:0] a, input logic [15:0] d);
        if (a >= 5'd1 && a <= 5'd13) sh_ctrl[a] = d[7:0];
        case (a)
            5'd16:   sh_mask = d;
            5'd18:   sh_wdv  = d[7:0];
            5'd19:   sh_sv0  = d[7:0];
            5'd20:   sh_sv1  = d[7:0];
            default: ;
        endcase
    endtask

    // write, optionally changing the lines on the same edge
    task automatic wr_lines(input logic [4:0] a, input logic [15:0] d,
                            input logic chg, input logic [13:0] nl);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        if (chg) irq_lines = nl;
        shadow_write(a, d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        wr_lines(a, d, 1'b0, '0);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_read(input string tag, input logic [4:0] a);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, shadow_read(a));
    endtask

    task automatic chk_out(input string tag);
        logic [10:0] e;
        e = model();
        chk({tag, " level"}, {13'd0, irq_level}, {13'd0, e[10:8]});
        chk({tag, " vector"}, {8'd0, irq_vector}, {8'd0, e[7:0]});
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 14; i++) sh_ctrl[i] = 8'h00;
        sh_ctrl[1] = 8'h04; sh_ctrl[2] = 8'h08; sh_ctrl[3] = 8'h0C; sh_ctrl[4] = 8'h10;
        sh_ctrl[5] = 8'h14; sh_ctrl[6] = 8'h18; sh_ctrl[7] = 8'h1C; sh_ctrl[8] = 8'h1C;
        sh_ctrl[9] = 8'h80; sh_ctrl[10] = 8'h80; sh_ctrl[11] = 8'h80;
        sh_mask = 16'h3FFE; sh_wdv = 8'h0F; sh_sv0 = 8'h0F; sh_sv1 = 8'h0F;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1: reset contents and quiet outputs
        for (int a = 0; a < 21; a++) chk_read("R1 reset read", 5'(a));
        chk_read("R11 unmapped read", 5'd25);
        chk_out("R1 reset outputs");

        // R4: all masked at reset, lines high give nothing
        @(negedge clk); irq_lines = 14'h3FFE;
        settle();
        chk_out("R4 masked by reset mask");

        // R2: line 0 alone has no effect
        wr(5'd16, 16'h0000);
        @(negedge clk); irq_lines = 14'h0001;
        settle();
        chk_read("R2 line0 not pending", 5'd17);
        chk_out("R2 line0 no output");

        // R3: pending is read-only
        wr(5'd17, 16'hFFFF);
        settle();
        chk_read("R3 pending unchanged", 5'd17);
        chk_out("R3 outputs unchanged");

        // R10: latency from a line change
        @(negedge clk); irq_lines = 14'h0020;
        @(negedge clk);
        chk("R10 one edge old", {13'd0, irq_level}, 16'd0);
        @(negedge clk);
        chk("R10 two edges level", {13'd0, irq_level}, 16'd5);
        chk("R10 two edges vector", {8'd0, irq_vector}, 16'h0F);

        // R10: latency from a register write
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'd5; reg_wdata = 16'h0098; shadow_write(5'd5, 16'h0098);
        @(negedge clk);
        reg_we = 1'b0;
        chk("R10 write old level", {13'd0, irq_level}, 16'd5);
        @(negedge clk);
        chk("R10 write new level", {13'd0, irq_level}, 16'd6);
        chk("R8 autovector 24+6", {8'd0, irq_vector}, 16'd30);

        // R5: tie goes to the lower line
        wr(5'd3, 16'h0094);
        wr(5'd5, 16'h0014);
        @(negedge clk); irq_lines = 14'h0028;
        settle();
        chk("R5 tie level", {13'd0, irq_level}, 16'd5);
        chk("R5 tie lower wins vector", {8'd0, irq_vector}, 16'd29);
        // R5: higher low-priority bits beat a lower line
        wr(5'd5, 16'h0015);
        settle();
        chk("R5 priority bits win", {8'd0, irq_vector}, 16'h0F);

        // R6: below cutoff gives nothing
        wr(5'd2, 16'h0083);
        @(negedge clk); irq_lines = 14'h0004;
        settle();
        chk("R6 cutoff level", {13'd0, irq_level}, 16'd0);
        chk("R6 cutoff vector", {8'd0, irq_vector}, 16'd0);

        // R9: each vector source
        wr(5'd18, 16'h0040); wr(5'd19, 16'h0041); wr(5'd20, 16'h0042);
        wr(5'd8, 16'h0008); wr(5'd12, 16'h000C); wr(5'd13, 16'h0010);
        @(negedge clk); irq_lines = 14'h0100;
        settle();
        chk("R9 watchdog vector", {8'd0, irq_vector}, 16'h40);
        chk("R7 level from bits 4:2", {13'd0, irq_level}, 16'd2);
        @(negedge clk); irq_lines = 14'h1000;
        settle();
        chk("R9 serial0 vector", {8'd0, irq_vector}, 16'h41);
        @(negedge clk); irq_lines = 14'h2000;
        settle();
        chk("R9 serial1 vector", {8'd0, irq_vector}, 16'h42);
        wr(5'd2, 16'h000C);
        @(negedge clk); irq_lines = 14'h0004;
        settle();
        chk("R9 fallback vector", {8'd0, irq_vector}, 16'h0F);

        // R4: masking the winner hands over to the next line
        @(negedge clk); irq_lines = 14'h2004;
        wr(5'd16, 16'h2000);
        settle();
        chk("R4 masked winner skipped", {8'd0, irq_vector}, 16'h0F);
        chk("R4 next level", {13'd0, irq_level}, 16'd3);

        // random mix, with writes and line changes on the same edge
        for (int it = 0; it < 500; it++) begin
            int op;
            logic [4:0]  a;
            logic [15:0] d;
            logic [13:0] nl;
            op = int'($urandom_range(0, 4));
            nl = 14'($urandom);
            d  = 16'($urandom);
            case (op)
                0: begin a = 5'($urandom_range(1, 13)); wr_lines(a, d, 1'b1, nl); end
                1: begin d = d & 16'($urandom) & 16'($urandom); wr_lines(5'd16, d, 1'b1, nl); end
                2: begin a = 5'($urandom_range(18, 20)); wr_lines(a, d, $urandom_range(0, 1) == 1, nl); end
                3: begin a = 5'($urandom_range(0, 31)); wr_lines(a, d, 1'b1, nl); end
                default: begin @(negedge clk); irq_lines = nl; end
            endcase
            settle();
            chk_out("R5 R7 R9 random");
            chk_read("R11 random readback", 5'($urandom_range(0, 31)));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule